// File: doc/BRIEF.md
# Panel Vertical Drive Timing Generator

This block produces the vertical control waveforms for a small active-matrix colour panel whose gate lines are scanned from top to bottom. It turns a line-rate tick and a field sync into five outputs. Two complementary shift-clock phases each spend one line high and one line low. A start pulse marks the line just before scanning begins. A gate-enable decides when the selected gate line may be driven. A parity flag flips once per field so that the video path can invert polarity from field to field.

A mode input picks the 60 Hz or the 50 Hz field format. The longer 50 Hz field must still fit the same number of panel lines. For that format the block holds back one clock advance at a fixed interval of incoming lines and pulls enable low for that line. When the last active line has been clocked, both phases freeze at their final levels and enable returns high. Everything then waits for the next field sync.

Top module: `panel_vtiming`

## Requirements
- R1: While `rst` is high, and on the first clock after it, the outputs are `vck_a`=0, `vck_b`=1, `gate_en`=1, `vstart`=0 and `field_odd`=0.
- R2: A cycle with `vsync`=1 returns the phases to `vck_a`=0/`vck_b`=1 with `gate_en`=1 on the next clock and restarts the field. A `line_tick` in that same cycle is ignored.
- R3: `vstart` is high from the clock after the first `line_tick` that follows `vsync` until the clock after the second such tick. At that second clock `vck_a` rises for the first time.
- R4: Each active line tick that is not held back swaps both phases on the next clock. `vck_a` and `vck_b` are never equal.
- R5: While scanning, `gate_en` goes high only on a clock where `vck_a` rises and goes low only where `vck_b` rises or a line is held back. In 60 Hz mode (`mode_50`=0) it equals `vck_a` during the field.
- R6: With `mode_50`=1, the 6th, 12th, 18th, ... active line tick after the start pulse leaves both phases unchanged and drives `gate_en` low for that line. Active ticks are counted from the tick that ends `vstart`.
- R7: After `ACTIVE_LINES` (225) phase advances, the next line tick sets `gate_en` to 1. Both phases then hold their levels, and further ticks change nothing until the next `vsync`.
- R8: `field_odd` inverts on the clock after every `vsync` cycle and is otherwise steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_tick | input | 1 | One-cycle pulse per horizontal line |
| vsync | input | 1 | One-cycle pulse at the start of a field |
| mode_50 | input | 1 | 1 selects 50 Hz field format, 0 selects 60 Hz |
| vck_a | output | 1 | First vertical shift-clock phase |
| vck_b | output | 1 | Second vertical shift-clock phase, complement of `vck_a` |
| gate_en | output | 1 | Gate-line enable, high when idle |
| vstart | output | 1 | Vertical start pulse, one line long |
| field_odd | output | 1 | Field parity for field-inversion drive |

## Verification
The assertions watch four rules on every cycle. The two phases must always be complementary. A phase may change only after a line tick or a sync. Enable edges must line up with the matching phase edges, and the clock advances in one field must never exceed the active line count. Start-pulse placement and the exact line that 50 Hz mode holds back are shown only by the bench's scenarios. So are the freeze after the last line, the priority of sync over a coincident tick, and recovery from a reset in mid-field. The bench follows each of these through whole fields, with sparse and dense tick patterns in both modes.

// File: rtl/pvt_pkg.sv
package pvt_pkg;

    typedef enum logic [1:0] {
        ST_HOLD  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LEAD  = 2'd2,
        ST_RUN   = 2'd3
    } vseq_e;

    typedef struct packed {
        logic rest;
        logic advance;
        logic withhold;
        logic finish;
    } vstep_t;

    function automatic int unsigned next_slot(int unsigned cur, int unsigned period);
        return (cur + 1 >= period) ? 0 : cur + 1;
    endfunction

    function automatic int unsigned width_of(int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/pvt_sequencer.sv
module pvt_sequencer
    import pvt_pkg::*;
#(
    parameter int unsigned ACTIVE_LINES = 225,
    parameter int unsigned SKIP_PERIOD  = 6
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   line_tick,
    input  logic   vsync,
    input  logic   mode_50,
    output vstep_t step,
    output logic   in_run,
    output logic   lead_line
);
    localparam int unsigned CNT_W = width_of(ACTIVE_LINES + 1);
    localparam int unsigned PH_W  = width_of(SKIP_PERIOD);

    vseq_e            state;
    logic [CNT_W-1:0] adv_cnt;
    logic [PH_W-1:0]  slot;
    logic             tick_act;
    logic             slot_hit;
    logic             last_done;

    generate
        if (SKIP_PERIOD > 1) begin : g_skip
            assign slot_hit = (slot == PH_W'(SKIP_PERIOD - 1));
        end else begin : g_noskip
            assign slot_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        tick_act      = line_tick && !vsync && (state == ST_LEAD || state == ST_RUN);
        last_done     = (adv_cnt == CNT_W'(ACTIVE_LINES));
        step.rest     = vsync;
        step.finish   = tick_act && (state == ST_RUN) && last_done;
        step.withhold = tick_act && !step.finish && mode_50 && slot_hit;
        step.advance  = tick_act && !step.finish && !step.withhold;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_HOLD;
            adv_cnt <= '0;
            slot    <= '0;
        end else if (vsync) begin
            state   <= ST_ARMED;
            adv_cnt <= '0;
            slot    <= '0;
        end else if (line_tick) begin
            case (state)
                ST_ARMED: state <= ST_LEAD;
                ST_LEAD, ST_RUN: begin
                    if (step.finish) begin
                        state <= ST_HOLD;
                    end else begin
                        state <= ST_RUN;
                        slot  <= PH_W'(next_slot(int'(slot), SKIP_PERIOD));
                        if (step.advance) adv_cnt <= adv_cnt + 1'b1;
                    end
                end
                default: state <= state;
            endcase
        end
    end

    assign in_run    = (state == ST_RUN);
    assign lead_line = (state == ST_LEAD);

endmodule

// File: rtl/pvt_phase.sv
module pvt_phase
    import pvt_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  vstep_t step,
    output logic   vck_a,
    output logic   vck_b,
    output logic   gate_en
);
    always_ff @(posedge clk) begin
        if (rst || step.rest) begin
            vck_a   <= 1'b0;
            vck_b   <= 1'b1;
            gate_en <= 1'b1;
        end else if (step.advance) begin
            vck_a   <= ~vck_a;
            vck_b   <= ~vck_b;
            gate_en <= ~vck_a;
        end else if (step.withhold) begin
            gate_en <= 1'b0;
        end else if (step.finish) begin
            gate_en <= 1'b1;
        end
    end
endmodule

// File: rtl/pvt_parity.sv
module pvt_parity (
    input  logic clk,
    input  logic rst,
    input  logic vsync,
    output logic field_odd
);
    always_ff @(posedge clk) begin
        if (rst)        field_odd <= 1'b0;
        else if (vsync) field_odd <= ~field_odd;
    end
endmodule

// File: rtl/panel_vtiming.sv
module panel_vtiming
    import pvt_pkg::*;
#(
    parameter int unsigned ACTIVE_LINES = 225,
    parameter int unsigned SKIP_PERIOD  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic line_tick,
    input  logic vsync,
    input  logic mode_50,
    output logic vck_a,
    output logic vck_b,
    output logic gate_en,
    output logic vstart,
    output logic field_odd
);
    vstep_t step;
    logic   field_run;

    pvt_sequencer #(
        .ACTIVE_LINES(ACTIVE_LINES),
        .SKIP_PERIOD (SKIP_PERIOD)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .line_tick(line_tick),
        .vsync    (vsync),
        .mode_50  (mode_50),
        .step     (step),
        .in_run   (field_run),
        .lead_line(vstart)
    );

    pvt_phase u_phase (
        .clk    (clk),
        .rst    (rst),
        .step   (step),
        .vck_a  (vck_a),
        .vck_b  (vck_b),
        .gate_en(gate_en)
    );

    pvt_parity u_par (
        .clk      (clk),
        .rst      (rst),
        .vsync    (vsync),
        .field_odd(field_odd)
    );

endmodule

// File: rtl/pvt_checker.sv
module pvt_checker #(
    parameter int unsigned ACTIVE_LINES = 225
) (
    input logic clk,
    input logic rst,
    input logic line_tick,
    input logic vsync,
    input logic vck_a,
    input logic vck_b,
    input logic gate_en,
    input logic vstart,
    input logic field_odd,
    input logic field_run
);
    logic        prev_a;
    logic        vsync_d;
    int unsigned edge_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_a   <= 1'b0;
            vsync_d  <= 1'b0;
            edge_cnt <= 0;
        end else begin
            prev_a  <= vck_a;
            vsync_d <= vsync;
            if (vsync_d)               edge_cnt <= 0;
            else if (vck_a != prev_a)  edge_cnt <= edge_cnt + 1;
        end
    end

    // R7: clock advances within a field stay within the active line count
    always_ff @(posedge clk) begin
        if (!rst) a_r7_edge_cap: assert (edge_cnt <= ACTIVE_LINES)
            else $error("edge count %0d above limit", edge_cnt);
    end

    a_r4_complement: assert property (@(posedge clk) disable iff (rst)
        vck_a != vck_b);

    a_r4_tick_only: assert property (@(posedge clk) disable iff (rst)
        (vck_a != $past(vck_a)) |-> ($past(line_tick) || $past(vsync)));

    a_r5_en_rise: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_en) && field_run) |-> $rose(vck_a));

    a_r5_en_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(gate_en) |-> ($rose(vck_b) || $stable(vck_a)));

    a_r3_start_on_tick: assert property (@(posedge clk) disable iff (rst)
        $rose(vstart) |-> $past(line_tick));

    a_r8_parity_flip: assert property (@(posedge clk) disable iff (rst)
        vsync |=> (field_odd != $past(field_odd)));

    a_r8_parity_hold: assert property (@(posedge clk) disable iff (rst)
        !vsync |=> $stable(field_odd));

endmodule

bind panel_vtiming pvt_checker #(.ACTIVE_LINES(ACTIVE_LINES)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .line_tick(line_tick),
    .vsync    (vsync),
    .vck_a    (vck_a),
    .vck_b    (vck_b),
    .gate_en  (gate_en),
    .vstart   (vstart),
    .field_odd(field_odd),
    .field_run(field_run)
);

// File: tb/sim_panel_vtiming.sv
module sim_panel_vtiming;
    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 225;
    localparam int SKIP       = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic line_tick = 1'b0;
    logic vsync = 1'b0;
    logic mode_50 = 1'b0;
    logic vck_a, vck_b, gate_en, vstart, field_odd;

    int total = 0;
    int bad   = 0;

    // bench model state: 0 idle/hold, 1 armed, 2 lead line, 3 scanning
    int   mst;
    int   madv;
    int   mj;
    logic mwith;
    logic ea, eb, een, efield;

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_vtiming u0 (
        .clk(clk), .rst(rst), .line_tick(line_tick), .vsync(vsync),
        .mode_50(mode_50), .vck_a(vck_a), .vck_b(vck_b), .gate_en(gate_en),
        .vstart(vstart), .field_odd(field_odd)
    );

    task automatic chk(input string tag, input logic got, input logic exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%0b exp=%0b at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic model_reset();
        mst = 0; madv = 0; mj = 0; mwith = 1'b0;
        ea = 1'b0; eb = 1'b1; een = 1'b1; efield = 1'b0;
    endtask

    task automatic model_step(input logic vs, input logic tk, input logic pal);
        if (vs) begin
            mst = 1; madv = 0; mj = 0; mwith = 1'b0;
            ea = 1'b0; eb = 1'b1; een = 1'b1; efield = ~efield;
        end else if (tk) begin
            if (mst == 1) begin
                mst = 2;
            end else if (mst == 2 || mst == 3) begin
                if (mst == 3 && madv == LINES) begin
                    mst = 0; een = 1'b1; mwith = 1'b0;
                end else begin
                    mst = 3;
                    mj++;
                    if (pal && (mj % SKIP == 0)) begin
                        een = 1'b0; mwith = 1'b1;
                    end else begin
                        madv++; ea = ~ea; eb = ~eb; een = ea; mwith = 1'b0;
                    end
                end
            end
        end
    endtask

    task automatic compare_all(input logic vs_cycle);
        string ctag;
        ctag = vs_cycle ? "R2" : (mst == 0 ? "R7" : "R4");
        chk({ctag, " vck_a"}, vck_a, ea);
        chk({ctag, " vck_b"}, vck_b, eb);
        chk(vs_cycle ? "R2 gate_en" : (mwith ? "R6 gate_en" : (mst == 0 ? "R7 gate_en" : "R5 gate_en")),
            gate_en, een);
        chk("R3 vstart", vstart, (mst == 2));
        chk("R8 field_odd", field_odd, efield);
    endtask

    task automatic step(input logic vs, input logic tk);
        vsync = vs; line_tick = tk;
        @(posedge clk);
        model_step(vs, tk, mode_50);
        @(negedge clk);
        compare_all(vs);
    endtask

    task automatic do_reset();
        rst = 1'b1; vsync = 1'b0; line_tick = 1'b0;
        @(posedge clk);
        @(negedge clk);
        model_reset();
        chk("R1 vck_a", vck_a, 1'b0);
        chk("R1 vck_b", vck_b, 1'b1);
        chk("R1 gate_en", gate_en, 1'b1);
        chk("R1 vstart", vstart, 1'b0);
        chk("R1 field_odd", field_odd, 1'b0);
        rst = 1'b0;
    endtask

    // full field: sync, ticks with probability pct, then a few ticks in hold (R7)
    task automatic run_field(input logic pal, input int pct);
        int guard;
        mode_50 = pal;
        step(1'b1, 1'b0);
        guard = 0;
        while (mst != 0 && guard < 4000) begin
            step(1'b0, ($urandom_range(0, 99) < pct));
            guard++;
        end
        chk("R7 field ended", (mst == 0), 1'b1);
        for (int i = 0; i < 8; i++) step(1'b0, 1'b1);
        chk("R7 phase held after field", vck_a, ea);
    endtask

    initial begin
        void'($urandom(32'd1234));
        model_reset();
        @(negedge clk);
        do_reset();
        // ticks before any sync are ignored (R7 hold state)
        for (int i = 0; i < 5; i++) step(1'b0, 1'b1);

        // R3: directed lead line check with dense ticks, 60 Hz
        mode_50 = 1'b0;
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R3 no start before tick", vstart, 1'b0);
        step(1'b0, 1'b1);
        chk("R3 start high", vstart, 1'b1);
        step(1'b0, 1'b0);
        chk("R3 start still high", vstart, 1'b1);
        step(1'b0, 1'b1);
        chk("R3 start low at first edge", vstart, 1'b0);
        chk("R3 first vck_a rise", vck_a, 1'b1);
        while (mst != 0) step(1'b0, 1'b1);

        run_field(1'b0, 100);
        run_field(1'b1, 100);
        run_field(1'b0, 40);
        run_field(1'b1, 55);

        // R6 directed: count held-back lines in a dense 50 Hz field
        begin
            int holds;
            holds = 0;
            mode_50 = 1'b1;
            step(1'b1, 1'b0);
            step(1'b0, 1'b1);
            for (int i = 0; i < 12; i++) begin
                step(1'b0, 1'b1);
                if (gate_en === 1'b0 && vck_a === 1'b1) holds++;
            end
            chk("R6 held-back lines seen", (holds >= 1), 1'b1);
        end

        // R2: sync in the middle of a field, coincident with a tick
        for (int i = 0; i < 30; i++) step(1'b0, 1'b1);
        step(1'b1, 1'b1);
        chk("R2 rest vck_a", vck_a, 1'b0);
        chk("R2 rest gate_en", gate_en, 1'b1);
        chk("R2 no start on same tick", vstart, 1'b0);
        for (int i = 0; i < 100; i++) step(1'b0, ($urandom_range(0, 1) == 1));

        // R1: reset in the middle of a field, then a fresh field
        do_reset();
        run_field(1'b0, 70);

        // random mix with occasional syncs and mode flips
        for (int i = 0; i < 3000; i++) begin
            if ($urandom_range(0, 99) == 0) mode_50 = ~mode_50;
            step(($urandom_range(0, 499) == 0), ($urandom_range(0, 99) < 60));
        end
        run_field(1'b1, 80);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule